// File: doc/BRIEF.md
# PIN Verifier with Retry Budget

This block decides whether a candidate personal identification number matches a stored reference, and it keeps the count of remaining attempts in hardware. A caller presents the candidate and the reference digits and pulses a start strobe. A small sequencer then compares one digit per clock. It always visits every digit, so the time to a verdict does not depend on where a mismatch sits. When the verdict is ready the block raises a one-cycle done pulse. An authenticated flag accompanies that pulse.

The block holds a retry budget. Every attempt is gated by it. A match refills the budget to its ceiling, and a miss takes one away. When a miss empties the budget, a sticky lockout output rises. After that, every request is refused at once, without any comparison. Only the active-low clear input (the block's asynchronous reset) brings the block back to a full budget with no lockout. Each digit is 4 bits wide and a PIN has 4 digits. Digit k occupies bits [4k+3:4k] of each PIN bus. The budget ceiling is 3. All three values are parameters.

Top module: `pinv_top`

## Requirements
- R1: While clear is held low, and after it is released, tries_o equals 3, done_o and auth_o are 0, and lock_o is 0.
- R2: When the candidate equals the reference on all 4 digits, done_o is 1 exactly 5 cycles after the cycle in which start_i was sampled, with auth_o 1 and tries_o reloaded to 3.
- R3: A mismatch in any single digit (the digit in bits [3:0] or the one in bits [15:12]) gives done_o with auth_o 0, and tries_o one lower than before the attempt.
- R4: The verdict latency is 5 cycles whether the first mismatching digit is the lowest, the highest, or absent.
- R5: A miss that takes tries_o from 1 to 0 raises lock_o in the same cycle as its done_o pulse.
- R6: Once lock_o is 1 it stays 1 until clear. A start while locked gives done_o one cycle after the sampled start, with auth_o 0, and tries_o stays 0, even with a matching candidate.
- R7: A start_i pulse while a comparison is running is ignored. It produces no extra done_o pulse and does not change the running attempt's result or the budget.
- R8: done_o is high for exactly one cycle per verdict, and auth_o is 0 whenever done_o is 0.
- R9: The candidate and the reference are captured in the cycle in which start_i is accepted. Changes on cand_i or ref_i during the comparison do not affect the verdict.
- R10: tries_o never exceeds 3 and changes only in a cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low clear; asynchronous assert, synchronised release |
| start_i | input | 1 | Request one verification attempt |
| cand_i | input | 16 | Candidate PIN, digit k in bits [4k+3:4k] |
| ref_i | input | 16 | Reference PIN, same layout |
| auth_o | output | 1 | Authenticated; meaningful only with done_o |
| done_o | output | 1 | One-cycle verdict strobe |
| tries_o | output | 2 | Remaining attempts |
| lock_o | output | 1 | Permanent lockout |

## Verification
An accepted comparison reports 5 cycles after the edge that samples start_i: one capture edge, then four digit edges, the last of which registers the verdict and the budget update. A refused request reports one cycle after its sampled start. For each attempt, the bench counts falling edges from the start edge until done_o appears. It checks that count against the exact figure, and it reads auth_o, tries_o and lock_o on that same falling edge. On the following falling edge it confirms that done_o has dropped again. This also catches a verdict that arrives early, late or twice, and catches the stray pulse that an ignored start could cause.

// File: rtl/pinv_pkg.sv
package pinv_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_t;
endpackage

// File: rtl/pinv_scan.sv
module pinv_scan
  import pinv_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int DW     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [DIGITS*DW-1:0] cand_i,
  input  logic [DIGITS*DW-1:0] ref_i,
  output logic                 busy_o,
  output logic                 fin_o,
  output logic                 equal_o
);
  localparam int PW = DIGITS * DW;
  localparam int IW = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam logic [IW-1:0] LAST = IW'(DIGITS - 1);

  scan_state_t   st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          miss_q, miss_d;
  logic [PW-1:0] cand_q, ref_q;
  logic [DW-1:0] cd, rd;
  logic          miss_now;

  // current digit pair, selected by the scan index
  always_comb begin
    cd       = cand_q[idx_q*DW +: DW];
    rd       = ref_q[idx_q*DW +: DW];
    miss_now = miss_q | (cd != rd);
  end

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    miss_d = miss_q;
    case (st_q)
      SCAN_IDLE: begin
        if (load_i) begin
          st_d   = SCAN_RUN;
          idx_d  = '0;
          miss_d = 1'b0;
        end
      end
      SCAN_RUN: begin
        miss_d = miss_now;
        if (idx_q == LAST) begin
          st_d  = SCAN_IDLE;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SCAN_IDLE;
      idx_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      miss_q <= miss_d;
    end
  end

  // operand capture, enabled only on an accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      ref_q  <= '0;
    end else if (load_i && (st_q == SCAN_IDLE)) begin
      cand_q <= cand_i;
      ref_q  <= ref_i;
    end
  end

  assign busy_o  = (st_q == SCAN_RUN);
  assign fin_o   = (st_q == SCAN_RUN) && (idx_q == LAST);
  assign equal_o = ~miss_now;
endmodule

// File: rtl/pinv_budget.sv
module pinv_budget #(
  parameter int MAX_TRIES = 3,
  localparam int TW = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin_i,
  input  logic          equal_i,
  input  logic          refuse_i,
  output logic [TW-1:0] tries_o,
  output logic          lock_o,
  output logic          done_o,
  output logic          auth_o
);
  localparam logic [TW-1:0] FULL = TW'(MAX_TRIES);
  localparam logic [TW-1:0] ONE  = TW'(1);

  logic [TW-1:0] tries_q, tries_d;
  logic          lock_q, lock_d;
  logic          done_q, done_d;
  logic          auth_q, auth_d;
  logic          upd_en;

  assign upd_en = fin_i;

  always_comb begin
    done_d  = fin_i | refuse_i;
    auth_d  = fin_i & equal_i;
    tries_d = tries_q;
    lock_d  = lock_q;
    if (equal_i) begin
      tries_d = FULL;
    end else if (tries_q != '0) begin
      tries_d = tries_q - ONE;
      if (tries_q == ONE) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      auth_q <= 1'b0;
    end else begin
      done_q <= done_d;
      auth_q <= auth_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries_q <= FULL;
      lock_q  <= 1'b0;
    end else if (upd_en) begin
      tries_q <= tries_d;
      lock_q  <= lock_d;
    end
  end

  assign tries_o = tries_q;
  assign lock_o  = lock_q;
  assign done_o  = done_q;
  assign auth_o  = auth_q;
endmodule

// File: rtl/pinv_top.sv
module pinv_top #(
  parameter int DIGITS    = 4,
  parameter int DW        = 4,
  parameter int MAX_TRIES = 3,
  localparam int PW = DIGITS * DW,
  localparam int TW = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [PW-1:0] cand_i,
  input  logic [PW-1:0] ref_i,
  output logic          auth_o,
  output logic          done_o,
  output logic [TW-1:0] tries_o,
  output logic          lock_o
);
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  logic       busy, fin, equal;
  logic       may_try, accept, refuse;

  // asynchronous assert, two-flop synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign may_try = ~lock_o & (tries_o != '0);
  assign accept  = start_i & ~busy & may_try;
  assign refuse  = start_i & ~busy & ~may_try;

  pinv_scan #(.DIGITS(DIGITS), .DW(DW)) u_scan (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .load_i  (accept),
    .cand_i  (cand_i),
    .ref_i   (ref_i),
    .busy_o  (busy),
    .fin_o   (fin),
    .equal_o (equal)
  );

  pinv_budget #(.MAX_TRIES(MAX_TRIES)) u_budget (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .fin_i    (fin),
    .equal_i  (equal & fin),
    .refuse_i (refuse),
    .tries_o  (tries_o),
    .lock_o   (lock_o),
    .done_o   (done_o),
    .auth_o   (auth_o)
  );
endmodule

// File: rtl/pinv_chk.sv
module pinv_chk #(
  parameter int MAX_TRIES = 3,
  localparam int TW = $clog2(MAX_TRIES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auth_o,
  input logic          done_o,
  input logic [TW-1:0] tries_o,
  input logic          lock_o
);
  localparam logic [TW-1:0] FULL = TW'(MAX_TRIES);

  assert_reload_on_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && auth_o) |-> (tries_o == FULL));

  assert_lock_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (tries_o == '0));

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> lock_o);

  assert_locked_denied_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && done_o && !$rose(lock_o)) |-> !auth_o);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_auth_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    auth_o |-> done_o);

  assert_tries_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tries_o <= FULL);

  assert_tries_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tries_o) |-> done_o);
endmodule

bind pinv_top pinv_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .auth_o  (auth_o),
  .done_o  (done_o),
  .tries_o (tries_o),
  .lock_o  (lock_o)
);

// File: tb/tb_pinv_top.sv
`timescale 1ns/1ps
module tb_pinv_top;
  localparam int DIGITS = 4;
  localparam int DW     = 4;
  localparam int MAXT   = 3;
  localparam int PW     = DIGITS * DW;
  localparam int TW     = $clog2(MAXT + 1);
  localparam int LAT_CMP = DIGITS + 1;
  localparam int LAT_REF = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [PW-1:0] cand_i, ref_i;
  logic          auth_o, done_o, lock_o;
  logic [TW-1:0] tries_o;

  int checks = 0;
  int errors = 0;

  localparam logic [PW-1:0] SECRET = 16'h4A7C;

  always #4 clk = ~clk;

  pinv_top #(.DIGITS(DIGITS), .DW(DW), .MAX_TRIES(MAXT)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cand_i(cand_i),
    .ref_i(ref_i), .auth_o(auth_o), .done_o(done_o), .tries_o(tries_o),
    .lock_o(lock_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one start, count falling edges to done, check the verdict there
  task automatic attempt(input logic [PW-1:0] c, input logic [PW-1:0] r,
                         input int lat, input int e_auth, input int e_tries,
                         input int e_lock, input string tag,
                         input bit poke_busy);
    int n;
    @(negedge clk);
    cand_i  = c;
    ref_i   = r;
    start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      n++;
      if (poke_busy && n == 2) begin
        // R7/R9: stray request and altered operands during the scan
        start_i = 1'b1;
        cand_i  = ~c;
        ref_i   = r ^ 16'h1111;
      end
      if (poke_busy && n == 3) start_i = 1'b0;
      if (done_o) break;
    end
    chk({tag, " latency"}, n, lat);
    chk({tag, " auth"}, int'(auth_o), e_auth);
    chk({tag, " tries"}, int'(tries_o), e_tries);
    chk({tag, " lock"}, int'(lock_o), e_lock);
    @(negedge clk);
    chk({tag, " R8 done drops"}, int'(done_o), 0);
    chk({tag, " R8 auth drops"}, int'(auth_o), 0);
    cand_i = c;
    ref_i  = r;
  endtask

  task automatic do_reset(input string tag);
    rst_n   = 1'b0;
    start_i = 1'b0;
    cand_i  = '0;
    ref_i   = SECRET;
    repeat (2) @(negedge clk);
    chk({tag, " R1 tries in reset"}, int'(tries_o), MAXT);
    chk({tag, " R1 lock in reset"}, int'(lock_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({tag, " R1 tries"}, int'(tries_o), MAXT);
    chk({tag, " R1 done"}, int'(done_o), 0);
    chk({tag, " R1 auth"}, int'(auth_o), 0);
    chk({tag, " R1 lock"}, int'(lock_o), 0);
  endtask

  task automatic t_pass();
    attempt(SECRET, SECRET, LAT_CMP, 1, MAXT, 0, "R2 pass", 1'b0);
  endtask

  task automatic t_miss_low();
    attempt(SECRET ^ 16'h0001, SECRET, LAT_CMP, 0, MAXT-1, 0, "R3 miss low digit", 1'b0);
  endtask

  task automatic t_miss_high();
    attempt(SECRET ^ 16'h8000, SECRET, LAT_CMP, 0, MAXT-2, 0, "R3 R4 miss high digit", 1'b0);
  endtask

  task automatic t_reload();
    attempt(SECRET, SECRET, LAT_CMP, 1, MAXT, 0, "R2 reload after misses", 1'b0);
  endtask

  task automatic t_busy();
    int extra;
    attempt(SECRET, SECRET, LAT_CMP, 1, MAXT, 0, "R7 R9 busy start", 1'b1);
    extra = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    chk("R7 no extra done", extra, 0);
    chk("R7 budget untouched", int'(tries_o), MAXT);
  endtask

  task automatic t_lockout();
    attempt(16'h0000, SECRET, LAT_CMP, 0, 2, 0, "R3 drain 1", 1'b0);
    attempt(16'hFFFF, SECRET, LAT_CMP, 0, 1, 0, "R3 drain 2", 1'b0);
    attempt(SECRET ^ 16'h0F00, SECRET, LAT_CMP, 0, 0, 1, "R5 last miss locks", 1'b0);
    attempt(SECRET, SECRET, LAT_REF, 0, 0, 1, "R6 refused when locked", 1'b0);
    repeat (5) @(negedge clk);
    chk("R6 lock holds", int'(lock_o), 1);
    chk("R6 tries hold", int'(tries_o), 0);
  endtask

  initial begin
    #(8ns * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset("start");
    t_pass();
    t_miss_low();
    t_miss_high();
    t_reload();
    t_busy();
    t_lockout();
    do_reset("R6 clear after lock");
    t_pass();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule